// File: doc/BRIEF.md
# Calorimeter Trigger-Cell Pulse Processor

This block takes twelve calorimeter trigger-cell channels, each delivering one 12-bit ADC sample on every clock of a 100 MHz stream. Every channel is scaled by its own gain coefficient and then searched for local maxima. Each local maximum is compared against a per-channel threshold. When a maximum qualifies as a peak it carries its corrected height and a hit flag.

Whenever at least one channel raises a hit in a given cycle, the block assembles a single 200-bit frame that holds all twelve channels. A programmable delay line then lines the frame up with frames from other boards before it goes to a serial link. Gain coefficients, thresholds, the dead time and the delay are loaded through a simple write port. That port also works while samples keep flowing.

Top module: `fadc_trig_proc`

## Requirements
- R1: While reset is high, and after reset until the first hit, `frame_valid_o` stays low.
- R2: The corrected amplitude of a channel is min((sample * gain) >> 6, 16383), where gain is an 8-bit per-channel value and 64 means unity. After reset every gain is 64.
- R3: A channel declares a peak on a corrected sample only when that sample is strictly greater than the one before it and the one after it is strictly smaller. Equal neighbours (a plateau) never produce a peak.
- R4: The hit bit of a peak is 1 when its corrected height is greater than or equal to the channel threshold (14 bits, reset value 16383), and 0 otherwise.
- R5: After a peak on a channel at sample index m, the next peak on that channel can be declared no earlier than sample m + D. D is the programmed dead time, but any value below 8 is treated as 8. The reset value is 8.
- R6: Frame layout. Bits [199:196] hold the header 4'hA. Channel k occupies bits [195-15k -: 15], laid out as {height[13:0], hit}. Bits [15:0] are zero.
- R7: `frame_valid_o` is high only for frames in which at least one channel has hit = 1. A channel that has no peak in that cycle reports height 0 and hit 0, and a peak without a hit reports its height with hit 0.
- R8: When a peak sample is presented at clock edge m, its frame appears after edge m + 5 + d, where d is the programmed delay (0 to 31).
- R9: Write-port map, using a 6-bit address. Addresses 0–11 hold the gain of channels 0–11, and 16–27 hold their thresholds. Address 32 holds the dead time (6 bits) and address 33 the delay (5 bits). Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_data_i | input | 144 | Twelve samples, channel k in bits [12k+11:12k] |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 6 | Configuration address |
| cfg_wdata_i | input | 14 | Configuration write data (low bits used per field) |
| frame_valid_o | output | 1 | Frame strobe |
| frame_o | output | 200 | Packed frame for the link |

## Verification
The bench attacks several corner cases, and each one exposes a specific kind of mistake.

- **Plateaus:** a design that compares with greater-or-equal would report a peak on a flat top.
- **Heights exactly at the threshold, and one count below it:** an off-by-one discriminator drops the first case or accepts the second.
- **Peak pairs at spacings around the dead time, including a programmed value under the floor of 8:** a wrong dead-time count, or a missing clamp, lets a second peak through or blocks a legal one.
- **Delays 0 and 31, plus random delays:** a wrong read pointer or a lost bypass shifts frames by a cycle, or replays stale ones.
- **Writes to unused addresses:** faulty decoding corrupts a gain.
- **Random pulses on noise under random gains and thresholds:** these exercise scaling, packing order and sub-threshold maxima that must consume dead time without raising a frame.

// File: rtl/fadc_trig_pkg.sv
package fadc_trig_pkg;
  localparam int NCH        = 12;
  localparam int SMP_W      = 12;
  localparam int GAIN_W     = 8;
  localparam int GAIN_FRAC  = 6;
  localparam int HGT_W      = 14;
  localparam int HDR_W      = 4;
  localparam int HDR_CODE   = 10;
  localparam int FRAME_W    = 200;
  localparam int DEAD_W     = 6;
  localparam int DEAD_MIN   = 8;
  localparam int DLY_DEPTH  = 32;
  localparam int CFG_AW     = 6;
  localparam int CFG_DW     = 14;
  localparam int GAIN_BASE  = 0;
  localparam int THR_BASE   = 16;
  localparam int DEAD_ADDR  = 32;
  localparam int DLY_ADDR   = 33;
endpackage

// File: rtl/ftp_cfg_regs.sv
module ftp_cfg_regs
  import fadc_trig_pkg::*;
#(
  parameter int N_CH    = NCH,
  parameter int G_W     = GAIN_W,
  parameter int G_FRAC  = GAIN_FRAC,
  parameter int H_W     = HGT_W,
  parameter int D_W     = DEAD_W,
  parameter int D_MIN   = DEAD_MIN,
  parameter int L_W     = 5,
  parameter int A_W     = CFG_AW,
  parameter int W_W     = CFG_DW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we_i,
  input  logic [A_W-1:0]     addr_i,
  input  logic [W_W-1:0]     wdata_i,
  output logic [N_CH*G_W-1:0] gain_o,
  output logic [N_CH*H_W-1:0] thr_o,
  output logic [D_W-1:0]     dead_o,
  output logic [L_W-1:0]     dly_o
);
  localparam logic [G_W-1:0] GAIN_UNITY = G_W'(1 << G_FRAC);

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        gain_o[ch*G_W +: G_W] <= GAIN_UNITY;
        thr_o[ch*H_W +: H_W]  <= '1;
      end else if (we_i) begin
        if (addr_i == A_W'(GAIN_BASE + ch)) gain_o[ch*G_W +: G_W] <= wdata_i[G_W-1:0];
        if (addr_i == A_W'(THR_BASE + ch))  thr_o[ch*H_W +: H_W]  <= wdata_i[H_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dead_o <= D_W'(D_MIN);
      dly_o  <= '0;
    end else if (we_i) begin
      if (addr_i == A_W'(DEAD_ADDR)) dead_o <= wdata_i[D_W-1:0];
      if (addr_i == A_W'(DLY_ADDR))  dly_o  <= wdata_i[L_W-1:0];
    end
  end
endmodule

// File: rtl/ftp_gain_corr.sv
module ftp_gain_corr
  import fadc_trig_pkg::*;
#(
  parameter int S_W    = SMP_W,
  parameter int G_W    = GAIN_W,
  parameter int G_FRAC = GAIN_FRAC,
  parameter int H_W    = HGT_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [S_W-1:0] smp_i,
  input  logic [G_W-1:0] gain_i,
  output logic [H_W-1:0] corr_o
);
  localparam int P_W = S_W + G_W;
  localparam logic [P_W-1:0] H_MAX = P_W'((1 << H_W) - 1);

  logic [S_W-1:0] smp_r;
  logic [P_W-1:0] prod;
  logic [P_W-1:0] scaled;

  always_comb begin
    prod   = P_W'(smp_r) * P_W'(gain_i);
    scaled = prod >> G_FRAC;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_r  <= '0;
      corr_o <= '0;
    end else begin
      smp_r  <= smp_i;
      corr_o <= (scaled > H_MAX) ? H_MAX[H_W-1:0] : scaled[H_W-1:0];
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R2
  unity_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(gain_i) == G_W'(1 << G_FRAC) && $past(smp_r) < S_W'((1 << H_W) - 1))
      |-> corr_o == H_W'($past(smp_r)));
endmodule

// File: rtl/ftp_peak_disc.sv
module ftp_peak_disc
  import fadc_trig_pkg::*;
#(
  parameter int H_W   = HGT_W,
  parameter int D_W   = DEAD_W,
  parameter int D_MIN = DEAD_MIN
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [H_W-1:0] corr_i,
  input  logic [H_W-1:0] thr_i,
  input  logic [D_W-1:0] dead_i,
  output logic           hit_o,
  output logic [H_W-1:0] hgt_o
);
  logic [H_W-1:0] p1, p2;
  logic [D_W-1:0] cnt, dead_eff;
  logic           is_max, take, pk_r;

  always_comb begin
    dead_eff = (dead_i < D_W'(D_MIN)) ? D_W'(D_MIN) : dead_i;
    is_max   = (p1 > p2) && (corr_i < p1);
    take     = is_max && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p1 <= '0; p2 <= '0; cnt <= '0;
      pk_r <= 1'b0; hit_o <= 1'b0; hgt_o <= '0;
    end else begin
      p2    <= p1;
      p1    <= corr_i;
      pk_r  <= take;
      hit_o <= take && (p1 >= thr_i);
      hgt_o <= take ? p1 : '0;
      if (take)            cnt <= dead_eff - D_W'(1);
      else if (cnt != '0)  cnt <= cnt - D_W'(1);
    end
  end

  logic       past_ok;
  logic [7:0] gap;
  always_ff @(posedge clk) begin
    past_ok <= !rst;
    if (rst)           gap <= 8'hFF;
    else if (pk_r)     gap <= 8'd1;
    else if (gap != 8'hFF) gap <= gap + 8'd1;
  end

  // R5
  dead_gap_chk: assert property (@(posedge clk) disable iff (rst)
    pk_r |-> gap >= 8'(D_MIN));
  // R4
  hit_thr_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && hit_o) |-> (pk_r && hgt_o >= $past(thr_i)));
  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !pk_r |-> (hgt_o == '0 && !hit_o));
endmodule

// File: rtl/ftp_delay_line.sv
module ftp_delay_line #(
  parameter int W     = 200,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] dly_i,
  input  logic          vld_i,
  input  logic [W-1:0]  dat_i,
  output logic          vld_o,
  output logic [W-1:0]  dat_o
);
  logic [W-1:0]     mem [DEPTH];
  logic [DEPTH-1:0] vmem;
  logic [AW-1:0]    wp, rp;

  assign rp = wp - dly_i;

  always_ff @(posedge clk) begin
    mem[wp] <= dat_i;
    dat_o   <= (dly_i == '0) ? dat_i : mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      vmem  <= '0;
      vld_o <= 1'b0;
    end else begin
      wp       <= wp + AW'(1);
      vmem[wp] <= vld_i;
      vld_o    <= (dly_i == '0) ? vld_i : vmem[rp];
    end
  end

  logic past_ok;
  always_ff @(posedge clk) past_ok <= !rst;

  // R8
  zero_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(dly_i) == '0) |-> vld_o == $past(vld_i));
endmodule

// File: rtl/fadc_trig_proc.sv
module fadc_trig_proc
  import fadc_trig_pkg::*;
#(
  parameter int N_CH   = NCH,
  parameter int S_W    = SMP_W,
  parameter int G_W    = GAIN_W,
  parameter int G_FRAC = GAIN_FRAC,
  parameter int H_W    = HGT_W,
  parameter int F_W    = FRAME_W,
  parameter int D_W    = DEAD_W,
  parameter int D_MIN  = DEAD_MIN,
  parameter int L_DEP  = DLY_DEPTH,
  parameter int A_W    = CFG_AW,
  parameter int W_W    = CFG_DW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_CH*S_W-1:0] adc_data_i,
  input  logic                cfg_we_i,
  input  logic [A_W-1:0]      cfg_addr_i,
  input  logic [W_W-1:0]      cfg_wdata_i,
  output logic                frame_valid_o,
  output logic [F_W-1:0]      frame_o
);
  localparam int FLD_W = H_W + 1;
  localparam int PAD_W = F_W - HDR_W - N_CH * FLD_W;
  localparam int L_W   = $clog2(L_DEP);

  logic [N_CH*G_W-1:0] gain_all;
  logic [N_CH*H_W-1:0] thr_all;
  logic [D_W-1:0]      dead;
  logic [L_W-1:0]      dly;
  logic [H_W-1:0]      corr [N_CH];
  logic [H_W-1:0]      hgt  [N_CH];
  logic [N_CH-1:0]     hit;
  logic [F_W-1:0]      frame_c, frame_r;
  logic                fvld_r;

  ftp_cfg_regs #(
    .N_CH(N_CH), .G_W(G_W), .G_FRAC(G_FRAC), .H_W(H_W), .D_W(D_W),
    .D_MIN(D_MIN), .L_W(L_W), .A_W(A_W), .W_W(W_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
    .wdata_i(cfg_wdata_i), .gain_o(gain_all), .thr_o(thr_all),
    .dead_o(dead), .dly_o(dly)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
    ftp_gain_corr #(.S_W(S_W), .G_W(G_W), .G_FRAC(G_FRAC), .H_W(H_W)) u_gain (
      .clk(clk), .rst(rst), .smp_i(adc_data_i[ch*S_W +: S_W]),
      .gain_i(gain_all[ch*G_W +: G_W]), .corr_o(corr[ch])
    );
    ftp_peak_disc #(.H_W(H_W), .D_W(D_W), .D_MIN(D_MIN)) u_peak (
      .clk(clk), .rst(rst), .corr_i(corr[ch]), .thr_i(thr_all[ch*H_W +: H_W]),
      .dead_i(dead), .hit_o(hit[ch]), .hgt_o(hgt[ch])
    );
  end

  always_comb begin
    frame_c = '0;
    frame_c[F_W-1 -: HDR_W] = HDR_W'(HDR_CODE);
    for (int ch = 0; ch < N_CH; ch++)
      frame_c[F_W-HDR_W-1-ch*FLD_W -: FLD_W] = {hgt[ch], hit[ch]};
  end

  always_ff @(posedge clk) begin
    frame_r <= frame_c;
    if (rst) fvld_r <= 1'b0;
    else     fvld_r <= |hit;
  end

  ftp_delay_line #(.W(F_W), .DEPTH(L_DEP)) u_dly (
    .clk(clk), .rst(rst), .dly_i(dly), .vld_i(fvld_r), .dat_i(frame_r),
    .vld_o(frame_valid_o), .dat_o(frame_o)
  );

  logic [N_CH-1:0] out_hits;
  always_comb
    for (int ch = 0; ch < N_CH; ch++)
      out_hits[ch] = frame_o[F_W-HDR_W-1-ch*FLD_W-H_W];

  // R6
  header_code_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> frame_o[F_W-1 -: HDR_W] == HDR_W'(HDR_CODE));
  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> frame_o[PAD_W-1:0] == '0);
  // R7
  frame_has_hit_chk: assert property (@(posedge clk) disable iff (rst)
    frame_valid_o |-> out_hits != '0);
endmodule

// File: tb/fadc_trig_proc_tb_top.sv
module fadc_trig_proc_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [143:0] adc_data = '0;
  logic         cfg_we = 1'b0;
  logic [5:0]   cfg_addr = '0;
  logic [13:0]  cfg_wdata = '0;
  logic         frame_valid_o;
  logic [199:0] frame_o;

  always #5 clk = ~clk;

  fadc_trig_proc dut_i (
    .clk(clk), .rst(rst), .adc_data_i(adc_data), .cfg_we_i(cfg_we),
    .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .frame_valid_o(frame_valid_o), .frame_o(frame_o)
  );

  int ec = 0;
  always @(posedge clk) ec <= ec + 1;

  int errs = 0, chks = 0;
  bit done = 0;
  string cur_tag = "R1";

  int xs [12];
  int g_m [12], thr_m [12], cm1 [12], cm2 [12], lastpk [12], ph [12], amp [12];
  int dead_m = 8, d_m = 0;
  bit          exp_v [256];
  logic [199:0] exp_f [256];
  bit cw_we = 0; int cw_a = 0, cw_d = 0;

  function automatic int corr_f(int s, int g);
    int v = (s * g) >> 6;
    return (v > 16383) ? 16383 : v;
  endfunction

  function automatic int shape_f(int p, int a);
    case (p)
      1: return a / 4;  2: return a / 2;  3: return a;
      4: return 3 * a / 4;  5: return a / 2;  default: return a / 4;
    endcase
  endfunction

  task automatic model_update(int k);
    logic [199:0] fr = '0;
    bit any = 0;
    int deff = (dead_m < 8) ? 8 : dead_m;
    fr[199:196] = 4'hA;
    for (int ch = 0; ch < 12; ch++) begin
      int c0 = corr_f(xs[ch], g_m[ch]);
      if (cm1[ch] > cm2[ch] && c0 < cm1[ch] && (k - 1 - lastpk[ch]) >= deff) begin
        bit h = (cm1[ch] >= thr_m[ch]);
        lastpk[ch] = k - 1;
        fr[195 - 15*ch -: 15] = {14'(cm1[ch]), h};
        if (h) any = 1;
      end
      cm2[ch] = cm1[ch];
      cm1[ch] = c0;
    end
    exp_v[(k - 1) % 256] = any;
    exp_f[(k - 1) % 256] = fr;
  endtask

  task automatic check_out();
    if (ec == 0) return;
    chks++;
    if (rst) begin
      if (frame_valid_o !== 1'b0) begin
        errs++;
        $display("FAIL R1: valid during reset act=%b exp=0", frame_valid_o);
      end
    end else begin
      int j = ec - 5 - d_m;
      bit ev = (j >= 0) ? exp_v[j % 256] : 1'b0;
      logic [199:0] ef = (j >= 0) ? exp_f[j % 256] : '0;
      if (frame_valid_o !== ev || (ev && frame_o !== ef)) begin
        errs++;
        $display("FAIL %s: cycle %0d valid act=%b exp=%b frame act=%h exp=%h",
                 cur_tag, ec, frame_valid_o, ev, frame_o, ef);
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    check_out();
    for (int ch = 0; ch < 12; ch++) adc_data[ch*12 +: 12] = 12'(xs[ch]);
    cfg_we = cw_we; cfg_addr = 6'(cw_a); cfg_wdata = 14'(cw_d);
    model_update(ec + 1);
  endtask

  task automatic flush(int n);
    for (int ch = 0; ch < 12; ch++) begin xs[ch] = 0; ph[ch] = 0; end
    repeat (n) step();
  endtask

  task automatic cfg_wr(int a, int d);
    cw_we = 1; cw_a = a; cw_d = d;
    for (int ch = 0; ch < 12; ch++) xs[ch] = 0;
    step();
    cw_we = 0;
    if (a < 12) g_m[a] = d & 255;
    else if (a >= 16 && a < 28) thr_m[a-16] = d & 16383;
    else if (a == 32) dead_m = d & 63;
    else if (a == 33) d_m = d & 31;
  endtask

  task automatic play(int ch, int v0, int v1, int v2, int v3);
    xs[ch] = v0; step(); xs[ch] = v1; step();
    xs[ch] = v2; step(); xs[ch] = v3; step();
    flush(12);
  endtask

  task automatic pair(int ch, int gap);
    for (int i = 0; i < gap + 3; i++) begin
      xs[ch] = (i == 1 || i == 1 + gap) ? 500 : 0;
      step();
    end
    flush(20);
  endtask

  task automatic rand_step();
    for (int ch = 0; ch < 12; ch++) begin
      int v = $urandom_range(0, 7);
      if (ph[ch] == 0 && $urandom_range(0, 11) == 0) begin
        ph[ch] = 1; amp[ch] = $urandom_range(0, 4095);
      end
      if (ph[ch] != 0) begin
        v += shape_f(ph[ch], amp[ch]);
        ph[ch] = (ph[ch] == 6) ? 0 : ph[ch] + 1;
      end
      xs[ch] = (v > 4095) ? 4095 : v;
    end
    step();
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int ch = 0; ch < 12; ch++) begin
      g_m[ch] = 64; thr_m[ch] = 16383; cm1[ch] = 0; cm2[ch] = 0;
      lastpk[ch] = -1000; xs[ch] = 0; ph[ch] = 0; amp[ch] = 0;
    end
    for (int i = 0; i < 256; i++) begin exp_v[i] = 0; exp_f[i] = '0; end
    // R1: reset state
    repeat (5) step();
    rst = 1'b0;
    flush(10);
    // R9: thresholds through the map, ignored addresses
    for (int ch = 0; ch < 12; ch++) cfg_wr(16 + ch, 100);
    cfg_wr(12, 0); cfg_wr(28, 0); cfg_wr(34, 5);
    flush(10);
    cur_tag = "R9";
    play(0, 50, 200, 150, 0);
    // R3: simple peak and plateau
    cur_tag = "R3";
    play(3, 80, 400, 120, 0);
    play(2, 300, 300, 0, 0);
    // R4: exactly at threshold, one below
    cur_tag = "R4";
    play(5, 0, 100, 0, 0);
    cur_tag = "R7";
    play(6, 0, 99, 0, 0);
    play(7, 0, 99, 0, 0);
    // R5: dead time with clamp and programmed value
    cur_tag = "R5";
    cfg_wr(32, 3); flush(5);
    pair(1, 6); pair(1, 7); pair(1, 8);
    cfg_wr(32, 12); flush(5);
    pair(4, 10); pair(4, 11); pair(4, 12);
    // R8: longest delay
    flush(40);
    cfg_wr(33, 31); flush(5);
    cur_tag = "R8";
    play(9, 10, 700, 20, 0);
    flush(40);
    // R2 / R6: random rounds
    for (int r = 0; r < 4; r++) begin
      flush(45);
      for (int ch = 0; ch < 12; ch++) cfg_wr(ch, $urandom_range(32, 255));
      for (int ch = 0; ch < 12; ch++) cfg_wr(16 + ch, $urandom_range(50, 3000));
      cfg_wr(32, $urandom_range(0, 40));
      cfg_wr(33, (r == 0) ? 0 : $urandom_range(1, 31));
      flush(5);
      cur_tag = (r % 2 == 0) ? "R2" : "R6";
      repeat (3000) rand_step();
    end
    flush(45);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errs++; chks++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule